// File: doc/BRIEF.md
# Fixed-Latency Comma Alignment Controller

This block sits behind a serial receiver's deserializer and receives one 20-bit parallel word per recovered-clock cycle, in an arbitrary bit alignment. It looks for a comma symbol at every bit offset and reports where the comma lies. It never shifts the data to correct the alignment. When the comma lies at the wrong offset, the block pulses a reset to the receiver, waits for the receiver to settle, and searches again. It repeats this until the recovered-clock phase puts the comma at a fixed target offset, so the receive latency is the same after every link start.

The receiver's phase-alignment-done signal is asynchronous. It passes through a two-flop synchronizer before the sequencer uses it. The detected offset stays visible on an output so that it can be used for latency measurement. A retry counter bounds the number of restarts and leads to a terminal fail state. After lock, the block keeps watching the stream and restarts when the comma moves to another offset.

Top module: `lac_align_ctrl`

## Requirements
- R1: While reset is asserted, and on release of reset, `xcvr_rst_o` is 1, `aligned_o` is 0, `fail_o` is 0 and `retries_o` is 0.
- R2: Each receiver reset pulse on `xcvr_rst_o` stays high for exactly RST_CYC clock cycles. `aligned_o` and `fail_o` are never high together with `xcvr_rst_o`.
- R3: After a reset pulse, no search starts until SETTLE_CYC cycles have passed and the synchronized `phase_done_i` is high. While `phase_done_i` stays low, the block issues no new pulse and does not assert `aligned_o`.
- R4: The search window is {current word, previous word}, with the previous word in bits 19:0. A comma is found at offset k (0 to 19) when window bits k+9:k equal 10'b0011111010 or 10'b1100000101. The lowest matching k is reported on `comma_ofs_o`.
- R5: A candidate offset is accepted only when it is found in SEARCH_HITS consecutive words. A missing comma or a change of offset restarts the run count.
- R6: An accepted offset other than TARGET_OFS causes a new reset pulse. Every new reset pulse increments `retries_o` by one.
- R7: An accepted offset equal to TARGET_OFS asserts `aligned_o`, and `comma_ofs_o` then equals TARGET_OFS.
- R8: When a retry is due and `retries_o` already equals RETRY_MAX, `fail_o` is asserted permanently. No further pulse follows, and `retries_o` stays unchanged.
- R9: While aligned, a comma found at another offset in LOSS_HITS consecutive words drops `aligned_o` and starts a new reset pulse. A shorter run that ends with a comma at the target offset leaves the lock in place.
- R10: If no offset is accepted within SEARCH_TMO cycles of search, a retry is due.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered parallel clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_word_i | input | WORD_W | Raw deserialized word |
| phase_done_i | input | 1 | Asynchronous phase-alignment-done from the receiver |
| xcvr_rst_o | output | 1 | Reset request to the receiver |
| aligned_o | output | 1 | Comma held at the target offset |
| fail_o | output | 1 | Retry budget exhausted |
| comma_ofs_o | output | $clog2(WORD_W) | Most recently detected comma offset |
| retries_o | output | $clog2(RETRY_MAX+1) | Number of reset pulses since reset |

## Verification
A word presented at one edge reaches the offset detector's register at that edge and affects the sequencer one edge later. An accepted offset therefore changes `aligned_o` or `xcvr_rst_o` one edge after the last qualifying word. `phase_done_i` adds two synchronizer edges before the sequencer sees it. The scoreboard queues the expected reset and lock events, with their offsets and retry counts. The monitor samples on falling edges and pops an event on each rising edge of `xcvr_rst_o` or `aligned_o`. It checks the pulse width in whole cycles, and it checks that lock arrives between DONE_DLY+SEARCH_HITS and DONE_DLY+SEARCH_HITS+6 cycles after the pulse ends, a window that covers the synchronizer and detector delays.

// File: rtl/lac_pkg.sv
package lac_pkg;
    typedef enum logic [2:0] {
        ST_RST,
        ST_SETTLE,
        ST_SEARCH,
        ST_LOCKED,
        ST_FAIL
    } lac_state_e;

    localparam int SYM_W = 10;
    localparam logic [SYM_W-1:0] COMMA_POS = 10'b0011111010;
    localparam logic [SYM_W-1:0] COMMA_NEG = 10'b1100000101;
endpackage

// File: rtl/lac_sync2.sv
module lac_sync2 (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic s1_q, s2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
        end else begin
            s1_q <= d_i;
            s2_q <= s1_q;
        end
    end

    assign q_o = s2_q;
endmodule

// File: rtl/lac_comma_finder.sv
module lac_comma_finder #(
    parameter int WORD_W = 20,
    parameter int OFS_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word_i,
    output logic              hit_o,
    output logic [OFS_W-1:0]  ofs_o
);
    import lac_pkg::*;

    typedef struct packed {
        logic [WORD_W-1:0] prev;
        logic              hit;
        logic [OFS_W-1:0]  ofs;
    } fnd_t;

    fnd_t d, q;
    logic [2*WORD_W-1:0] win;
    logic [WORD_W-1:0]   match;

    assign win = {word_i, q.prev};

    for (genvar g = 0; g < WORD_W; g++) begin : g_ofs
        assign match[g] = (win[g+SYM_W-1:g] == COMMA_POS) ||
                          (win[g+SYM_W-1:g] == COMMA_NEG);
    end

    always_comb begin
        d      = q;
        d.prev = word_i;
        d.hit  = 1'b0;
        d.ofs  = '0;
        // Scan downward so the lowest matching offset wins (R4).
        for (int i = WORD_W - 1; i >= 0; i--) begin
            if (match[i]) begin
                d.hit = 1'b1;
                d.ofs = OFS_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign hit_o = q.hit;
    assign ofs_o = q.ofs;
endmodule

// File: rtl/lac_align_ctrl.sv
module lac_align_ctrl #(
    parameter int WORD_W      = 20,
    parameter int TARGET_OFS  = 7,
    parameter int RST_CYC     = 16,
    parameter int SETTLE_CYC  = 256,
    parameter int SEARCH_HITS = 8,
    parameter int LOSS_HITS   = 4,
    parameter int RETRY_MAX   = 255,
    parameter int SEARCH_TMO  = 1024,
    localparam int OFS_W      = $clog2(WORD_W),
    localparam int RTY_W      = $clog2(RETRY_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] rx_word_i,
    input  logic              phase_done_i,
    output logic              xcvr_rst_o,
    output logic              aligned_o,
    output logic              fail_o,
    output logic [OFS_W-1:0]  comma_ofs_o,
    output logic [RTY_W-1:0]  retries_o
);
    import lac_pkg::*;

    localparam int CNT_A   = (RST_CYC > SETTLE_CYC) ? RST_CYC : SETTLE_CYC;
    localparam int CNT_MAX = (CNT_A > SEARCH_TMO) ? CNT_A : SEARCH_TMO;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int HIT_MAX = (SEARCH_HITS > LOSS_HITS) ? SEARCH_HITS : LOSS_HITS;
    localparam int HIT_W   = $clog2(HIT_MAX + 1);

    typedef struct packed {
        lac_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [HIT_W-1:0]  run;
        logic [OFS_W-1:0]  ofs;
        logic [RTY_W-1:0]  rty;
    } ctl_t;

    ctl_t d, q;
    logic             done_s;
    logic             hit;
    logic [OFS_W-1:0] hit_ofs;
    logic             retry;
    logic [HIT_W-1:0] run_inc;

    lac_sync2 u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (phase_done_i),
        .q_o (done_s)
    );

    lac_comma_finder #(
        .WORD_W (WORD_W),
        .OFS_W  (OFS_W)
    ) u_find (
        .clk    (clk),
        .rst    (rst),
        .word_i (rx_word_i),
        .hit_o  (hit),
        .ofs_o  (hit_ofs)
    );

    always_comb begin
        d       = q;
        retry   = 1'b0;
        run_inc = q.run + 1'b1;
        unique case (q.st)
            ST_RST: begin
                if (q.cnt == CNT_W'(RST_CYC - 1)) begin
                    d.st  = ST_SETTLE;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_SETTLE: begin
                if (q.cnt != CNT_W'(SETTLE_CYC - 1)) begin
                    d.cnt = q.cnt + 1'b1;
                end else if (done_s) begin
                    d.st  = ST_SEARCH;
                    d.cnt = '0;
                    d.run = '0;
                end
            end
            ST_SEARCH: begin
                d.cnt = q.cnt + 1'b1;
                if (hit) begin
                    if (q.run != '0 && hit_ofs == q.ofs) d.run = run_inc;
                    else                                 d.run = HIT_W'(1);
                    d.ofs = hit_ofs;
                    if (d.run == HIT_W'(SEARCH_HITS)) begin
                        if (hit_ofs == OFS_W'(TARGET_OFS)) begin
                            d.st  = ST_LOCKED;
                            d.run = '0;
                        end else begin
                            retry = 1'b1;
                        end
                    end else if (q.cnt == CNT_W'(SEARCH_TMO - 1)) begin
                        retry = 1'b1;
                    end
                end else begin
                    d.run = '0;
                    if (q.cnt == CNT_W'(SEARCH_TMO - 1)) retry = 1'b1;
                end
            end
            ST_LOCKED: begin
                if (hit) begin
                    if (hit_ofs != OFS_W'(TARGET_OFS)) begin
                        d.run = run_inc;
                        if (run_inc == HIT_W'(LOSS_HITS)) retry = 1'b1;
                    end else begin
                        d.run = '0;
                    end
                end
            end
            default: ;
        endcase

        if (retry) begin
            if (q.rty == RTY_W'(RETRY_MAX)) begin
                d.st = ST_FAIL;
            end else begin
                d.st  = ST_RST;
                d.cnt = '0;
                d.run = '0;
                d.rty = q.rty + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.st  <= ST_RST;
            q.cnt <= '0;
            q.run <= '0;
            q.ofs <= '0;
            q.rty <= '0;
        end else begin
            q <= d;
        end
    end

    assign xcvr_rst_o  = (q.st == ST_RST);
    assign aligned_o   = (q.st == ST_LOCKED);
    assign fail_o      = (q.st == ST_FAIL);
    assign comma_ofs_o = q.ofs;
    assign retries_o   = q.rty;
endmodule

// File: rtl/lac_align_ctrl_chk.sv
module lac_align_ctrl_chk #(
    parameter int OFS_W      = 5,
    parameter int RTY_W      = 8,
    parameter int TARGET_OFS = 7,
    parameter int RETRY_MAX  = 255
) (
    input logic             clk,
    input logic             rst,
    input logic             xcvr_rst_o,
    input logic             aligned_o,
    input logic             fail_o,
    input logic [OFS_W-1:0] comma_ofs_o,
    input logic [RTY_W-1:0] retries_o
);
    assert_rst_excl_R2: assert property (@(posedge clk) disable iff (rst)
        xcvr_rst_o |-> (!aligned_o && !fail_o));

    assert_retry_step_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(xcvr_rst_o) |-> (retries_o == RTY_W'($past(retries_o) + 1)));

    assert_lock_offset_R7: assert property (@(posedge clk) disable iff (rst)
        aligned_o |-> (comma_ofs_o == OFS_W'(TARGET_OFS)));

    assert_fail_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        fail_o |=> (fail_o && $stable(retries_o) && !xcvr_rst_o));

    assert_retry_cap_R8: assert property (@(posedge clk) disable iff (rst)
        retries_o <= RTY_W'(RETRY_MAX));
endmodule

bind lac_align_ctrl lac_align_ctrl_chk #(
    .OFS_W      (OFS_W),
    .RTY_W      (RTY_W),
    .TARGET_OFS (TARGET_OFS),
    .RETRY_MAX  (RETRY_MAX)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .xcvr_rst_o  (xcvr_rst_o),
    .aligned_o   (aligned_o),
    .fail_o      (fail_o),
    .comma_ofs_o (comma_ofs_o),
    .retries_o   (retries_o)
);

// File: tb/lac_align_ctrl_tb.sv
module lac_align_ctrl_tb;
    localparam int WW       = 20;
    localparam int TGT      = 7;
    localparam int RSTC     = 4;
    localparam int SETC     = 8;
    localparam int NH       = 3;
    localparam int MH       = 2;
    localparam int RMAX     = 5;
    localparam int TMO      = 64;
    localparam int DONE_DLY = 12;
    localparam logic [9:0] KP   = 10'b0011111010;
    localparam logic [9:0] KN   = 10'b1100000101;
    localparam logic [9:0] FILL = 10'b0101010101;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [WW-1:0] rx_word = '0;
    logic          phase_done = 1'b0;
    logic          xcvr_rst_o, aligned_o, fail_o;
    logic [4:0]    comma_ofs_o;
    logic [2:0]    retries_o;

    always #5 clk = ~clk;

    lac_align_ctrl #(
        .WORD_W (WW), .TARGET_OFS (TGT), .RST_CYC (RSTC), .SETTLE_CYC (SETC),
        .SEARCH_HITS (NH), .LOSS_HITS (MH), .RETRY_MAX (RMAX), .SEARCH_TMO (TMO)
    ) u_dut (
        .clk (clk), .rst (rst), .rx_word_i (rx_word), .phase_done_i (phase_done),
        .xcvr_rst_o (xcvr_rst_o), .aligned_o (aligned_o), .fail_o (fail_o),
        .comma_ofs_o (comma_ofs_o), .retries_o (retries_o)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Receiver model: offset 0..19 = comma there, 20 = no comma, 21 = 7/9 flicker
    int  plan[$];
    int  cur = 20;
    bit  pol = 1'b0;
    bit  hold_done = 1'b1;
    bit  flick = 1'b0;
    int  dcnt = 0;
    logic prev_rst = 1'b1;

    function automatic logic [WW-1:0] mk_word(input int ofs, input bit p);
        logic [19:0]   s;
        logic [WW-1:0] w;
        int ph;
        if (ofs >= 20) return {2{FILL}};
        s  = {FILL, p ? KN : KP};
        ph = (20 - ofs) % 20;
        for (int j = 0; j < WW; j++) w[j] = s[(j + ph) % 20];
        return w;
    endfunction

    always @(negedge clk) begin
        int eff;
        if (xcvr_rst_o) begin
            phase_done = 1'b0;
            dcnt       = 0;
        end else begin
            if (prev_rst) begin
                if (plan.size() > 0) cur = plan.pop_front();
                pol = ~pol;
            end
            if (dcnt < DONE_DLY) dcnt++;
            else if (!hold_done) phase_done = 1'b1;
        end
        prev_rst = xcvr_rst_o;
        if (cur == 21) begin
            flick = ~flick;
            eff   = flick ? 7 : 9;
        end else begin
            eff = cur;
        end
        rx_word = mk_word(eff, pol);
    end

    // Scoreboard: kind 0 = reset pulse, kind 1 = lock
    typedef struct {int kind; int ofs; int rty;} ev_t;
    ev_t sb[$];

    task automatic expect_ev(input int kind, input int ofs, input int rty);
        ev_t e;
        e.kind = kind; e.ofs = ofs; e.rty = rty;
        sb.push_back(e);
    endtask

    logic m_rst = 1'b1, m_al = 1'b0;
    int   hi_cnt = 0, since_fall = 0;
    bit   pulse_ok = 1'b0;

    always @(negedge clk) begin
        ev_t e;
        if (!rst) begin
            if (xcvr_rst_o && !m_rst) begin
                pulse_ok = 1'b1;
                hi_cnt   = 0;
                if (sb.size() == 0) begin
                    check(0, "R6", "unexpected reset pulse", 1, 0);
                end else begin
                    e = sb.pop_front();
                    check(e.kind == 0, "R6", "event kind at pulse", 0, e.kind);
                    check(int'(retries_o) == e.rty, "R6", "retry count", retries_o, e.rty);
                    if (e.ofs >= 0)
                        check(int'(comma_ofs_o) == e.ofs, "R4", "detected offset", comma_ofs_o, e.ofs);
                end
            end
            if (xcvr_rst_o) hi_cnt++;
            if (!xcvr_rst_o && m_rst && pulse_ok)
                check(hi_cnt == RSTC, "R2", "pulse width", hi_cnt, RSTC);
            if (!xcvr_rst_o && m_rst) since_fall = 0;
            else since_fall++;
            if (aligned_o && !m_al) begin
                if (sb.size() == 0) begin
                    check(0, "R7", "unexpected lock", 1, 0);
                end else begin
                    e = sb.pop_front();
                    check(e.kind == 1, "R7", "event kind at lock", 1, e.kind);
                    check(int'(comma_ofs_o) == e.ofs, "R7", "lock offset", comma_ofs_o, e.ofs);
                    check(int'(retries_o) == e.rty, "R7", "retries at lock", retries_o, e.rty);
                    check(since_fall >= DONE_DLY + NH && since_fall <= DONE_DLY + NH + 6,
                          "R3", "lock latency after pulse", since_fall, DONE_DLY + NH);
                end
            end
            m_rst = xcvr_rst_o;
            m_al  = aligned_o;
        end
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            check(0, "R1", "watchdog expired", cyc, 100000);
            finish_run();
        end
    end

    task automatic wait_level(input int which, input bit val);
        int g = 0;
        while (g < 5000) begin
            @(negedge clk);
            g++;
            if (which == 0 && aligned_o == val) break;
            if (which == 1 && fail_o == val) break;
        end
    endtask

    initial begin
        plan.push_back(3); plan.push_back(12); plan.push_back(7);
        repeat (5) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(xcvr_rst_o == 1'b1, "R1", "xcvr_rst after reset", xcvr_rst_o, 1);
        check(aligned_o == 1'b0 && fail_o == 1'b0, "R1", "flags after reset", aligned_o | fail_o, 0);
        check(retries_o == 0, "R1", "retries after reset", retries_o, 0);
        rst = 1'b0;
        @(negedge clk);
        check(xcvr_rst_o == 1'b1 && retries_o == 0, "R1", "state on release", xcvr_rst_o, 1);

        expect_ev(0, 3, 1);
        expect_ev(0, 12, 2);
        expect_ev(1, TGT, 2);

        // R3: done held low, nothing proceeds
        repeat (100) @(negedge clk);
        check(xcvr_rst_o == 1'b0 && aligned_o == 1'b0, "R3", "idle while done low",
              xcvr_rst_o | aligned_o, 0);
        check(retries_o == 0, "R3", "no retry while done low", retries_o, 0);
        @(posedge clk);
        hold_done = 1'b0;

        wait_level(0, 1'b1);
        check(aligned_o == 1'b1 && comma_ofs_o == TGT, "R7", "locked at target", comma_ofs_o, TGT);

        // R9: single foreign word does not break lock
        @(posedge clk); cur = 2;
        @(posedge clk); cur = 7;
        repeat (10) @(negedge clk);
        check(aligned_o == 1'b1 && xcvr_rst_o == 1'b0, "R9", "lock kept after short run", aligned_o, 1);

        // R9: persistent foreign offset restarts
        expect_ev(0, TGT, 3);
        expect_ev(1, TGT, 3);
        plan.push_back(7);
        @(posedge clk); cur = 2;
        wait_level(0, 1'b0);
        check(aligned_o == 1'b0, "R9", "lock dropped", aligned_o, 0);
        wait_level(0, 1'b1);
        check(aligned_o == 1'b1, "R9", "relocked", aligned_o, 1);

        // R5/R10 via flicker then no comma; R8 on exhausted budget
        expect_ev(0, TGT, 4);
        expect_ev(0, -1, 5);
        plan.push_back(21); plan.push_back(20);
        @(posedge clk); cur = 2;
        wait_level(1, 1'b1);
        check(fail_o == 1'b1, "R8", "fail asserted", fail_o, 1);
        check(retries_o == RMAX, "R8", "retries at fail", retries_o, RMAX);
        repeat (300) @(negedge clk);
        check(fail_o == 1'b1 && xcvr_rst_o == 1'b0 && aligned_o == 1'b0, "R8",
              "fail is terminal", xcvr_rst_o, 0);
        check(retries_o == RMAX, "R8", "retries frozen", retries_o, RMAX);
        check(sb.size() == 0, "R10", "all expected events seen", sb.size(), 0);
        finish_run();
    end
endmodule